// File: doc/BRIEF.md
# Two-Stage Service Watchdog

This block guards a processor against a runaway program. A binary counter advances once per machine cycle, marked by a one-clock `tick` strobe. Each time the counter passes its all-ones value it expires. Two warning stages record these expiries. The first expiry with no service raises the first stage. A second unserviced expiry raises the second stage. A third expiry then raises a reset request for the rest of the system. A restart command from software clears both stages, so a request is made only when two whole service windows in a row pass with no restart.

Two more commands act on the block. A disable command turns the watchdog off for good, but only when it is given in the clock cycle right after a restart command, and only before the counter has expired for the first time since reset. A power-down notice clears the counter and both stages, so that a sleeping system does not wake up into a pending expiry. After a system reset the block is enabled, the counter is zero and both stages are clear.

Top module: `wdt_two_stage`

## Requirements
- R1: After reset, `rst_req` is low, the counter is zero, both stages are clear and the watchdog is enabled.
- R2: The counter advances only on clock edges where `tick` is high. An expiry occurs on the tick that finds the counter at all ones, which is once every 2^CNT_W ticks while the block is enabled.
- R3: An expiry with both stages clear sets the first stage. An expiry with only the first stage set sets the second stage. An expiry with the second stage set raises `rst_req`. Unserviced, the request therefore follows the third expiry after reset.
- R4: `rst_req` rises on the clock edge of the expiring tick. It stays high through the cycles with no tick and falls on the edge of the next tick, so it lasts exactly one machine cycle.
- R5: `cmd_restart` clears both stages and leaves the counter running.
- R6: A restart on the same edge as an expiry wins. Both stages end clear and no request is raised by that expiry.
- R7: `cmd_disable` is honoured only when `cmd_restart` was high on the edge just before and no expiry has yet occurred since reset. Once it is honoured, the counter stops and no request is ever raised.
- R8: A `cmd_disable` that misses either condition of R7 has no effect.
- R9: `cmd_powerdown` sets the counter to zero and clears both stages. This takes priority over a tick on the same edge.
- R10: Only reset sets the enable flag again. No command re-enables a disabled watchdog.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| tick | input | 1 | One-clock strobe per machine cycle |
| cmd_restart | input | 1 | Service command: clears both stages |
| cmd_disable | input | 1 | Request to turn the watchdog off |
| cmd_powerdown | input | 1 | Power-down notice: clears counter and stages |
| rst_req | output | 1 | Reset request, high for one machine cycle |

## Verification
The main function is tried with a free-running tick and no service, which places the request on exactly the third expiry and separates one-stage, two-stage and three-stage designs. A second pattern services the block regularly. Others service it once after the second stage is raised, or on the very edge of an expiry, and these show whether a restart clears both stages and whether it wins that edge. A tick on every other clock shows that the count follows the tick rather than the clock, and that the request stretches across the idle cycles. The disable and power-down patterns compare the expected request edge with the shifted or missing edge that a correct gate or counter clear produces.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    // Warning stages raised by unserviced expiries
    typedef struct packed {
        logic stage2;
        logic stage1;
    } wdt_flags_t;

    // Command strobes as one bundle
    typedef struct packed {
        logic restart;
        logic dis;
        logic powerdown;
    } wdt_cmd_t;

    // Next stage state after an expiry (second stage is sticky)
    function automatic wdt_flags_t stage_advance(wdt_flags_t f);
        wdt_flags_t n;
        n = f;
        if (!f.stage1) n.stage1 = 1'b1;
        else           n.stage2 = 1'b1;
        return n;
    endfunction

endpackage

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int CNT_W = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic run,
    input  logic clear,
    output logic expire
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt;

    assign expire = run && tick && !clear && (cnt == CNT_MAX);

    always_ff @(posedge clk) begin
        if (rst || clear)     cnt <= '0;
        else if (run && tick) cnt <= cnt + 1'b1;
    end

    // R2: no tick, no movement
    a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
        (!tick && !clear) |=> $stable(cnt));

    // R9: power-down leaves the counter at zero
    a_r9_clear_zeroes: assert property (@(posedge clk) disable iff (rst)
        clear |=> (cnt == '0));

    // R7: a stopped counter holds its value
    a_r7_frozen_when_off: assert property (@(posedge clk) disable iff (rst)
        (!run && !clear) |=> $stable(cnt));
endmodule

// File: rtl/wdt_flag_stage.sv
module wdt_flag_stage
    import wdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       expire,
    input  logic       restart,
    input  logic       powerdown,
    output logic       fire,
    output wdt_flags_t flags
);
    wdt_flags_t flags_nxt;

    assign fire = expire && flags.stage2 && !restart && !powerdown;

    always_comb begin
        flags_nxt = flags;
        if (expire)               flags_nxt = stage_advance(flags);
        if (restart || powerdown) flags_nxt = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= flags_nxt;
    end

    // R5: a restart leaves both stages clear
    a_r5_restart_clears: assert property (@(posedge clk) disable iff (rst)
        restart |=> (flags == '0));

    // R3: the second stage is raised only over a raised first stage
    a_r3_stage_order: assert property (@(posedge clk) disable iff (rst)
        $rose(flags.stage2) |-> $past(flags.stage1));
endmodule

// File: rtl/wdt_enable_gate.sv
module wdt_enable_gate (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic dis,
    input  logic expire,
    output logic en
);
    logic prev_restart;
    logic fresh;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_restart <= 1'b0;
            fresh        <= 1'b1;
            en           <= 1'b1;
        end else begin
            prev_restart <= restart;
            if (expire) fresh <= 1'b0;
            if (dis && prev_restart && fresh) en <= 1'b0;
        end
    end

    // R10: only reset brings the enable flag back
    a_r10_no_reenable: assert property (@(posedge clk) disable iff (rst)
        $rose(en) |-> $past(rst));

    // R7: a drop of the enable flag needs a disable right after a restart
    a_r7_fall_needs_prime: assert property (@(posedge clk) disable iff (rst)
        $fell(en) |-> ($past(dis) && $past(prev_restart)));
endmodule

// File: rtl/wdt_req_stretch.sv
module wdt_req_stretch (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic fire,
    output logic req
);
    always_ff @(posedge clk) begin
        if (rst)       req <= 1'b0;
        else if (fire) req <= 1'b1;
        else if (tick) req <= 1'b0;
    end

    // R4: the request spans idle cycles
    a_r4_hold_until_tick: assert property (@(posedge clk) disable iff (rst)
        (req && !tick && !fire) |=> req);

    // R4: the next tick ends the request
    a_r4_drop_on_tick: assert property (@(posedge clk) disable iff (rst)
        (req && tick && !fire) |=> !req);
endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage
    import wdt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic cmd_restart,
    input  logic cmd_disable,
    input  logic cmd_powerdown,
    output logic rst_req
);
    wdt_cmd_t   cmd;
    wdt_flags_t flags;
    logic       en;
    logic       expire;
    logic       fire;

    assign cmd = '{restart: cmd_restart, dis: cmd_disable, powerdown: cmd_powerdown};

    wdt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .run    (en),
        .clear  (cmd.powerdown),
        .expire (expire)
    );

    wdt_flag_stage u_stage (
        .clk       (clk),
        .rst       (rst),
        .expire    (expire),
        .restart   (cmd.restart),
        .powerdown (cmd.powerdown),
        .fire      (fire),
        .flags     (flags)
    );

    wdt_enable_gate u_gate (
        .clk     (clk),
        .rst     (rst),
        .restart (cmd.restart),
        .dis     (cmd.dis),
        .expire  (expire),
        .en      (en)
    );

    wdt_req_stretch u_req (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .fire (fire),
        .req  (rst_req)
    );

    // R3: a request starts only from a raised second stage
    a_r3_req_from_stage2: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_req) |-> $past(flags.stage2));

    // R7: a disabled block never asks for reset
    a_r7_silent_when_off: assert property (@(posedge clk) disable iff (rst)
        (!en && !rst_req) |=> !rst_req);

    // R1: reset leaves the request low
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> !rst_req);
endmodule

// File: tb/wdt_two_stage_tb.sv
module wdt_two_stage_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0;
    logic cmd_restart = 1'b0;
    logic cmd_disable = 1'b0;
    logic cmd_powerdown = 1'b0;
    logic rst_req;

    int checks = 0;
    int fails  = 0;
    int step_no = 0;
    bit done = 1'b0;

    typedef struct {
        int    step;
        logic  val;
        string tag;
    } exp_t;

    exp_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    wdt_two_stage #(.CNT_W(CNT_W)) u_dut (
        .clk           (clk),
        .rst           (rst),
        .tick          (tick),
        .cmd_restart   (cmd_restart),
        .cmd_disable   (cmd_disable),
        .cmd_powerdown (cmd_powerdown),
        .rst_req       (rst_req)
    );

    task automatic check(logic act, logic exp, string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: rst_req=%0b expected %0b at step %0d", tag, act, exp, step_no);
        end
    endtask

    task automatic expect_at(int step, logic val, string tag);
        exp_t e;
        e.step = step;
        e.val  = val;
        e.tag  = tag;
        q.push_back(e);
    endtask

    // Monitor: compares queued expectations after each step
    always @(posedge clk) begin
        #2;
        while (q.size() > 0 && q[0].step == step_no) begin
            exp_t e;
            e = q.pop_front();
            check(rst_req, e.val, e.tag);
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        tick = 1'b0;
        cmd_restart = 1'b0;
        cmd_disable = 1'b0;
        cmd_powerdown = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        step_no = 0;
        check(rst_req, 1'b0, "R1");
    endtask

    // Driver: runs steps up to 'upto'; -1 marks an unused command step
    task automatic drive(int upto, bit odd_ticks, int svc, int ra, int rb, int dis, int pd);
        for (int s = step_no + 1; s <= upto; s++) begin
            @(negedge clk);
            tick          = odd_ticks ? (s % 2 == 1) : 1'b1;
            cmd_restart   = (s == ra) || (s == rb) || (svc > 0 && s % svc == 0);
            cmd_disable   = (s == dis);
            cmd_powerdown = (s == pd);
            @(posedge clk);
            #1;
            step_no = s;
        end
        @(negedge clk);
        tick = 1'b0;
        cmd_restart = 1'b0;
        cmd_disable = 1'b0;
        cmd_powerdown = 1'b0;
        if (q.size() != 0) begin
            checks++;
            fails++;
            $display("FAIL scoreboard: %0d items left, expected 0", q.size());
            q.delete();
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog: run hung, expected completion");
        finish_run();
    end

    initial begin
        // R3/R4: no service, request on the third expiry
        do_reset();
        expect_at(16, 1'b0, "R3");
        expect_at(32, 1'b0, "R3");
        expect_at(47, 1'b0, "R4");
        expect_at(48, 1'b1, "R3");
        expect_at(49, 1'b0, "R4");
        drive(50, 1'b0, 0, -1, -1, -1, -1);

        // R5: regular service keeps the request away
        do_reset();
        expect_at(48, 1'b0, "R5");
        expect_at(64, 1'b0, "R5");
        expect_at(96, 1'b0, "R5");
        drive(100, 1'b0, 12, -1, -1, -1, -1);

        // R5: restart after the second stage clears both stages
        do_reset();
        expect_at(48, 1'b0, "R5");
        expect_at(64, 1'b0, "R5");
        expect_at(80, 1'b1, "R5");
        drive(81, 1'b0, 0, 40, -1, -1, -1);

        // R2/R4: tick on odd steps only; tick 48 falls on step 95
        do_reset();
        expect_at(94, 1'b0, "R2");
        expect_at(95, 1'b1, "R2");
        expect_at(96, 1'b1, "R4");
        expect_at(97, 1'b0, "R4");
        drive(98, 1'b1, 0, -1, -1, -1, -1);

        // R7/R10: honoured disable, later commands do not re-enable
        do_reset();
        expect_at(48, 1'b0, "R7");
        expect_at(64, 1'b0, "R10");
        expect_at(100, 1'b0, "R10");
        drive(100, 1'b0, 0, 1, 60, 2, 70);

        // R8: disable with no preceding restart
        do_reset();
        expect_at(48, 1'b1, "R8");
        drive(49, 1'b0, 0, -1, -1, 1, -1);

        // R8: disable after the first expiry
        do_reset();
        expect_at(48, 1'b0, "R8");
        expect_at(64, 1'b1, "R8");
        drive(65, 1'b0, 0, 20, -1, 21, -1);

        // R8: restart and disable not adjacent
        do_reset();
        expect_at(48, 1'b1, "R8");
        drive(49, 1'b0, 0, 1, -1, 3, -1);

        // R9: power-down restarts the count and clears the stages
        do_reset();
        expect_at(48, 1'b0, "R9");
        expect_at(87, 1'b0, "R9");
        expect_at(88, 1'b1, "R9");
        drive(89, 1'b0, 0, -1, -1, -1, 40);

        // R6: restart on the expiring edge wins
        do_reset();
        expect_at(48, 1'b0, "R6");
        expect_at(64, 1'b1, "R6");
        drive(65, 1'b0, 0, 16, -1, -1, -1);

        finish_run();
    end
endmodule